// File: doc/BRIEF.md
# Multidrop JTAG Address Selection Controller

Many bridges can share a single backplane JTAG port. Each one then has to decide on its own whether it joins the next scan operations. This controller makes that decision. While the bridge is unselected, the controller waits for an address. When the TAP reports Update-IR, it takes the value just shifted into the instruction register and classifies it. The value can be this bridge's own slot number, the interrogation address, the broadcast address, or one of the multicast group addresses. A group address counts only when this bridge belongs to that group. Any other value leaves the bridge unselected.

A successful match moves the controller into a selected state that records how it was addressed. The controller also drives the output enable of the shared backplane TDO driver. A bridge addressed by its slot number, or through interrogation, drives TDO during shift states like an ordinary TAP. A bridge addressed through broadcast or a group never drives TDO, so several bridges on the same wire cannot fight over it.

The controller returns to the unselected state in three ways: the TAP enters Test-Logic-Reset, TRST is asserted, or the dedicated release instruction is loaded while the bridge is selected.

Top module: `mdsel_ctrl`

## Requirements
- R1: While trst_n is low, and right after it goes low, every selection output and tdo_oe are 0, even with tap_shift high.
- R2: In the unselected state, an Update-IR cycle selects the bridge in unique mode (selected=1, sel_unique=1) on the next cycle when the captured value equals the nonzero slot_id. The slot_id must not be one of the special addresses. In this mode tdo_oe follows tap_shift.
- R3: An Update-IR whose value matches neither the slot_id nor any special address leaves the bridge unselected.
- R4: An address of 0 never selects the bridge, even when slot_id is 0.
- R5: The value 0x7B selects broadcast mode (sel_bcast=1). In this mode tdo_oe stays 0 even while tap_shift is high.
- R6: The values 0x7C to 0x7F stand for groups 0 to 3. Such a value selects group mode (sel_group=1) only if bit g of group_en is set. In group mode tdo_oe stays 0 while shifting.
- R7: The value 0x7A selects interrogation mode (sel_query=1). In this mode tdo_oe follows tap_shift.
- R8: While the bridge is selected, an Update-IR with the release instruction 0xC0 returns it to the unselected state on the next cycle. Any other Update-IR value leaves the mode unchanged.
- R9: tap_tlr high on a clock edge puts the bridge in the unselected state.
- R10: A change of ir_value without tap_update_ir never changes the selection outputs.
- R11: The special meaning of an address wins over slot_id: with slot_id=0x7B, the value 0x7B gives broadcast mode. A captured value with any bit set above the 7 address bits is not an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_tlr | input | 1 | TAP is in Test-Logic-Reset |
| tap_update_ir | input | 1 | TAP is in Update-IR |
| tap_shift | input | 1 | TAP is in Shift-IR or Shift-DR |
| ir_value | input | IR_W | Captured instruction register value |
| slot_id | input | ADDR_W | Static slot address pins |
| group_en | input | GROUPS | Multicast group membership bits |
| selected | output | 1 | Bridge takes part in scan operations |
| sel_unique | output | 1 | Selected through its own slot address |
| sel_bcast | output | 1 | Selected through the broadcast address |
| sel_group | output | 1 | Selected through a multicast group address |
| sel_query | output | 1 | Selected through the interrogation address |
| tdo_oe | output | 1 | Output enable of the backplane TDO driver |

## Verification
The bench builds the block with its default parameters: a 7-bit address, an 8-bit instruction register, four groups and release code 0xC0. With these values every special address (0x7A to 0x7F) can be reached directly, as can the reserved zero address. The 8-bit register also lets the bench load a value whose low 7 bits equal the slot number but whose top bit is set, which shows that such a value is not treated as an address. Because slot_id and group_en are ordinary inputs, the bench can set a slot equal to a special address or to zero, and can change group membership between scenarios.

// File: rtl/mdsel_pkg.sv
package mdsel_pkg;

  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_UNIQUE = 3'd1,
    ST_BCAST  = 3'd2,
    ST_GROUP  = 3'd3,
    ST_QUERY  = 3'd4
  } sel_state_e;

  typedef enum logic [2:0] {
    HIT_NONE   = 3'd0,
    HIT_UNIQUE = 3'd1,
    HIT_BCAST  = 3'd2,
    HIT_GROUP  = 3'd3,
    HIT_QUERY  = 3'd4
  } hit_kind_e;

  // selected state that a given address hit leads to
  function automatic sel_state_e hit_to_state(hit_kind_e h);
    case (h)
      HIT_UNIQUE: return ST_UNIQUE;
      HIT_BCAST:  return ST_BCAST;
      HIT_GROUP:  return ST_GROUP;
      HIT_QUERY:  return ST_QUERY;
      default:    return ST_WAIT;
    endcase
  endfunction

  // TDO is driven only in modes where a single responder is expected
  function automatic logic state_drives_tdo(sel_state_e s);
    return (s == ST_UNIQUE) || (s == ST_QUERY);
  endfunction

endpackage

// File: rtl/mdsel_decode.sv
module mdsel_decode
  import mdsel_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IR_W   = 8,
  parameter int GROUPS = 4
) (
  input  logic [IR_W-1:0]   ir_value,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic [GROUPS-1:0] group_en,
  output hit_kind_e         hit
);
  localparam int unsigned A_TOP   = (1 << ADDR_W) - 1;
  localparam int unsigned A_GBASE = A_TOP - GROUPS + 1;
  localparam int unsigned A_BC    = A_GBASE - 1;
  localparam int unsigned A_QRY   = A_GBASE - 2;
  localparam int          GIW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  localparam logic [ADDR_W-1:0] GBASE_V = ADDR_W'(A_GBASE);
  localparam logic [ADDR_W-1:0] BC_V    = ADDR_W'(A_BC);
  localparam logic [ADDR_W-1:0] QRY_V   = ADDR_W'(A_QRY);

  // a captured value is an address only if nothing is set above the address field
  function automatic logic fits_address(logic [IR_W-1:0] v);
    return (v >> ADDR_W) == '0;
  endfunction

  function automatic logic [GIW-1:0] group_index(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - GBASE_V;
    return off[GIW-1:0];
  endfunction

  logic [ADDR_W-1:0] addr;
  logic              addr_ok;
  logic [GIW-1:0]    gidx;

  assign addr    = ir_value[ADDR_W-1:0];
  assign addr_ok = fits_address(ir_value) && (addr != '0);
  assign gidx    = group_index(addr);

  always_comb begin
    hit = HIT_NONE;
    if (addr_ok) begin
      if (addr >= GBASE_V)      hit = group_en[gidx] ? HIT_GROUP : HIT_NONE;
      else if (addr == BC_V)    hit = HIT_BCAST;
      else if (addr == QRY_V)   hit = HIT_QUERY;
      else if (addr == slot_id) hit = HIT_UNIQUE;
    end
  end
endmodule

// File: rtl/mdsel_fsm.sv
module mdsel_fsm
  import mdsel_pkg::*;
#(
  parameter int          IR_W       = 8,
  parameter int unsigned UNSEL_CODE = 'hC0
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tap_tlr,
  input  logic            tap_update_ir,
  input  logic [IR_W-1:0] ir_value,
  input  hit_kind_e       hit,
  output sel_state_e      state,
  output logic            evt_accept,
  output logic            evt_release
);
  localparam logic [IR_W-1:0] REL_V = IR_W'(UNSEL_CODE);

  assign evt_accept  = tap_update_ir && (state == ST_WAIT) && (hit != HIT_NONE);
  assign evt_release = tap_update_ir && (state != ST_WAIT) && (ir_value == REL_V);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          state <= ST_WAIT;
    else if (tap_tlr)     state <= ST_WAIT;
    else if (evt_accept)  state <= hit_to_state(hit);
    else if (evt_release) state <= ST_WAIT;
  end
endmodule

// File: rtl/mdsel_outs.sv
module mdsel_outs
  import mdsel_pkg::*;
(
  input  sel_state_e state,
  input  logic       tap_shift,
  output logic       selected,
  output logic       sel_unique,
  output logic       sel_bcast,
  output logic       sel_group,
  output logic       sel_query,
  output logic       tdo_oe
);
  assign selected   = (state != ST_WAIT);
  assign sel_unique = (state == ST_UNIQUE);
  assign sel_bcast  = (state == ST_BCAST);
  assign sel_group  = (state == ST_GROUP);
  assign sel_query  = (state == ST_QUERY);
  assign tdo_oe     = tap_shift && state_drives_tdo(state);
endmodule

// File: rtl/mdsel_ctrl.sv
module mdsel_ctrl
  import mdsel_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          IR_W       = 8,
  parameter int          GROUPS     = 4,
  parameter int unsigned UNSEL_CODE = 'hC0
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tap_tlr,
  input  logic              tap_update_ir,
  input  logic              tap_shift,
  input  logic [IR_W-1:0]   ir_value,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic [GROUPS-1:0] group_en,
  output logic              selected,
  output logic              sel_unique,
  output logic              sel_bcast,
  output logic              sel_group,
  output logic              sel_query,
  output logic              tdo_oe
);
  hit_kind_e  hit;
  sel_state_e state;
  logic       evt_accept;
  logic       evt_release;

  mdsel_decode #(.ADDR_W(ADDR_W), .IR_W(IR_W), .GROUPS(GROUPS)) u_decode (
    .ir_value (ir_value),
    .slot_id  (slot_id),
    .group_en (group_en),
    .hit      (hit)
  );

  mdsel_fsm #(.IR_W(IR_W), .UNSEL_CODE(UNSEL_CODE)) u_fsm (
    .tck           (tck),
    .trst_n        (trst_n),
    .tap_tlr       (tap_tlr),
    .tap_update_ir (tap_update_ir),
    .ir_value      (ir_value),
    .hit           (hit),
    .state         (state),
    .evt_accept    (evt_accept),
    .evt_release   (evt_release)
  );

  mdsel_outs u_outs (
    .state      (state),
    .tap_shift  (tap_shift),
    .selected   (selected),
    .sel_unique (sel_unique),
    .sel_bcast  (sel_bcast),
    .sel_group  (sel_group),
    .sel_query  (sel_query),
    .tdo_oe     (tdo_oe)
  );
endmodule

// File: rtl/mdsel_ctrl_chk.sv
module mdsel_ctrl_chk #(
  parameter int          ADDR_W     = 7,
  parameter int          IR_W       = 8,
  parameter int          GROUPS     = 4,
  parameter int unsigned UNSEL_CODE = 'hC0
) (
  input logic              tck,
  input logic              trst_n,
  input logic              tap_tlr,
  input logic              tap_update_ir,
  input logic              tap_shift,
  input logic [IR_W-1:0]   ir_value,
  input logic [ADDR_W-1:0] slot_id,
  input logic              selected,
  input logic              sel_unique,
  input logic              sel_bcast,
  input logic              sel_group,
  input logic              sel_query,
  input logic              tdo_oe
);
  localparam logic [ADDR_W-1:0] FIRST_SPECIAL = ADDR_W'((1 << ADDR_W) - GROUPS - 2);

  AST_WAIT_NO_OE: assert property (@(posedge tck) disable iff (!trst_n)
    !selected |-> !tdo_oe);                                              // R1
  AST_UNIQUE_HIT: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_update_ir && !tap_tlr && !selected && slot_id != '0 && slot_id < FIRST_SPECIAL
     && ir_value == IR_W'(slot_id)) |=> sel_unique);                     // R2
  AST_ZERO_NO_SEL: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_update_ir && !selected && ir_value == '0) |=> !selected);       // R4
  AST_SHARED_NO_OE: assert property (@(posedge tck) disable iff (!trst_n)
    (sel_bcast || sel_group) |-> !tdo_oe);                               // R5
  AST_ONE_MODE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({sel_unique, sel_bcast, sel_group, sel_query}));            // R6
  AST_RELEASE: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_update_ir && selected && ir_value == IR_W'(UNSEL_CODE)) |=> !selected); // R8
  AST_TLR_WAIT: assert property (@(posedge tck) disable iff (!trst_n)
    tap_tlr |=> !selected);                                              // R9
  AST_HOLD_NO_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (!tap_update_ir && !tap_tlr) |=>
      $stable({selected, sel_unique, sel_bcast, sel_group, sel_query})); // R10
  AST_OE_NEEDS_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> tap_shift);                                               // R7
endmodule

bind mdsel_ctrl mdsel_ctrl_chk #(
  .ADDR_W(ADDR_W), .IR_W(IR_W), .GROUPS(GROUPS), .UNSEL_CODE(UNSEL_CODE)
) u_chk (
  .tck(tck), .trst_n(trst_n), .tap_tlr(tap_tlr), .tap_update_ir(tap_update_ir),
  .tap_shift(tap_shift), .ir_value(ir_value), .slot_id(slot_id),
  .selected(selected), .sel_unique(sel_unique), .sel_bcast(sel_bcast),
  .sel_group(sel_group), .sel_query(sel_query), .tdo_oe(tdo_oe)
);

// File: tb/test_mdsel_ctrl.sv
module test_mdsel_ctrl;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tap_tlr = 1'b0;
  logic       tap_update_ir = 1'b0;
  logic       tap_shift = 1'b0;
  logic [7:0] ir_value = 8'h00;
  logic [6:0] slot_id = 7'h15;
  logic [3:0] group_en = 4'b0000;
  logic selected, sel_unique, sel_bcast, sel_group, sel_query, tdo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 tck = ~tck;

  mdsel_ctrl i_mdsel_ctrl (
    .tck(tck), .trst_n(trst_n), .tap_tlr(tap_tlr), .tap_update_ir(tap_update_ir),
    .tap_shift(tap_shift), .ir_value(ir_value), .slot_id(slot_id), .group_en(group_en),
    .selected(selected), .sel_unique(sel_unique), .sel_bcast(sel_bcast),
    .sel_group(sel_group), .sel_query(sel_query), .tdo_oe(tdo_oe)
  );

  // expected vector order: {selected, unique, bcast, group, query}
  task automatic chk_mode(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {selected, sel_unique, sel_bcast, sel_group, sel_query};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s mode got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic chk_oe(string req, logic shift, logic exp);
    tap_shift = shift;
    #1;
    checks++;
    if (tdo_oe !== exp) begin
      errors++;
      $display("FAIL %s tdo_oe(shift=%0b) got=%b exp=%b", req, shift, tdo_oe, exp);
    end
    tap_shift = 1'b0;
  endtask

  task automatic upd(logic [7:0] v);
    @(negedge tck);
    ir_value = v;
    tap_update_ir = 1'b1;
    @(negedge tck);
    tap_update_ir = 1'b0;
  endtask

  task automatic go_wait();
    @(negedge tck);
    tap_tlr = 1'b1;
    @(negedge tck);
    tap_tlr = 1'b0;
    chk_mode("R9", 5'b00000);
  endtask

  task automatic t_reset();
    #1;
    chk_mode("R1", 5'b00000);
    chk_oe("R1", 1'b1, 1'b0);
    @(negedge tck);
    trst_n = 1'b1;
  endtask

  task automatic t_unique();
    upd(8'h15);
    chk_mode("R2", 5'b11000);
    chk_oe("R2", 1'b1, 1'b1);
    chk_oe("R2", 1'b0, 1'b0);
    go_wait();
  endtask

  task automatic t_mismatch();
    upd(8'h16);
    chk_mode("R3", 5'b00000);
    upd(8'h79);
    chk_mode("R3", 5'b00000);
  endtask

  task automatic t_zero();
    slot_id = 7'h00;
    upd(8'h00);
    chk_mode("R4", 5'b00000);
    slot_id = 7'h15;
  endtask

  task automatic t_bcast();
    upd(8'h7B);
    chk_mode("R5", 5'b10100);
    chk_oe("R5", 1'b1, 1'b0);
    go_wait();
  endtask

  task automatic t_group();
    group_en = 4'b0100;
    upd(8'h7C);
    chk_mode("R6", 5'b00000);
    upd(8'h7E);
    chk_mode("R6", 5'b10010);
    chk_oe("R6", 1'b1, 1'b0);
    go_wait();
    group_en = 4'b1000;
    upd(8'h7F);
    chk_mode("R6", 5'b10010);
    go_wait();
    group_en = 4'b0000;
  endtask

  task automatic t_query();
    upd(8'h7A);
    chk_mode("R7", 5'b10001);
    chk_oe("R7", 1'b1, 1'b1);
    go_wait();
  endtask

  task automatic t_release();
    upd(8'h15);
    chk_mode("R8", 5'b11000);
    upd(8'h33);
    chk_mode("R8", 5'b11000);
    upd(8'h7B);
    chk_mode("R8", 5'b11000);
    upd(8'hC0);
    chk_mode("R8", 5'b00000);
  endtask

  task automatic t_no_update();
    @(negedge tck);
    ir_value = 8'h15;
    repeat (3) @(negedge tck);
    chk_mode("R10", 5'b00000);
    upd(8'h15);
    ir_value = 8'hC0;
    repeat (3) @(negedge tck);
    chk_mode("R10", 5'b11000);
    go_wait();
  endtask

  task automatic t_reserved();
    slot_id = 7'h7B;
    upd(8'h7B);
    chk_mode("R11", 5'b10100);
    go_wait();
    slot_id = 7'h15;
    upd(8'h95);
    chk_mode("R11", 5'b00000);
  endtask

  task automatic t_async_trst();
    upd(8'h15);
    chk_mode("R1", 5'b11000);
    trst_n = 1'b0;
    #1;
    chk_mode("R1", 5'b00000);
    @(negedge tck);
    trst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_unique();
    t_mismatch();
    t_zero();
    t_bcast();
    t_group();
    t_query();
    t_release();
    t_no_update();
    t_reserved();
    t_async_trst();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule